// File: doc/BRIEF.md
# Prescaled Single-Channel PWM Timer

This block generates one pulse-width-modulated output from a free-running up-counter. A power-of-two prescaler slows the input clock by 1 to 128, and each prescaled tick advances the counter, which wraps to zero after it reaches the reload value. The output is the comparison of the counter against a compare value, optionally inverted by a polarity bit.

Software drives the block through six word-addressed registers on a simple single-cycle bus. The waveform shape (prescaler, polarity) may only be changed while the timer is off. The period and duty values may only be changed while it is on. Those two writes land after a fixed settling delay, and each one raises its own completion flag, which software later clears. A typical setup turns the timer off, sets the shape, turns it on, writes reload and compare, waits for both flags and then issues a start.

Top module: `lpwm_timer`

## Requirements
- R1: After reset every readable register returns 0 and `pwm_out` is 0.
- R2: A write to the shape register (address 1: bits [2:0] prescale exponent, bit 3 polarity) takes effect only while the enable bit is 0; while enabled it is ignored.
- R3: Writes to reload (address 2) and compare (address 3) are ignored while the enable bit is 0.
- R4: A reload or compare write accepted while enabled takes effect WR_LAT (3) clock edges after the accepting edge. The reload flag (status bit 0) or compare flag (status bit 1) at address 4 sets on that edge. Before then, a read returns the previous value.
- R5: Writing 1 to a bit of the clear register (address 5) clears the matching status flag, and writing 0 leaves it unchanged. A completion in the same cycle wins over the clear. Reads of address 5 return 0.
- R6: With prescale exponent p and reload value L, the output period is (L+1)*2^p clock cycles.
- R7: With polarity 0, the output is high while the counter is above the compare value C. That gives (L-C)*2^p high cycles per period when C<L, and a constantly low output when C>=L.
- R8: With polarity 1 the running waveform is inverted. While the timer is disabled, `pwm_out` equals the polarity bit.
- R9: Control register (address 0): write bit 0 is enable and bit 1 is start. A read returns {running, enable} in bits [1:0]. Start takes effect only if enable was already 1 before the write. Writing enable 0 stops counting and resets the counter and prescaler.
- R10: Read data appears on `bus_rdata` one cycle after `bus_rd` is sampled. It is 0 in any cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_rd | input | 1 | Read strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W | Word address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| pwm_out | output | 1 | Registered PWM waveform |

## Verification
The waveform is swept over prescale exponents 0 to 3, several reload values and every compare value from 0 up to one past the reload value. Each combination is run with both polarities. The high time counted over exactly one period separates correct compare and wrap behaviour from off-by-one errors at C=L-1, C=L and C>L. Prescaler errors show up as a wrong period between rising edges. Directed sequences separate ignored writes from accepted ones by reading the register back through the bus. They also catch a missing settling delay, by reading the old value one cycle after a write. A start issued while the timer is off is checked to be refused, and a start while on to be honoured.

// File: rtl/lpwm_pkg.sv
package lpwm_pkg;
  localparam int unsigned PRESC_W = 3;
  localparam int unsigned ADDR_CTRL   = 0;
  localparam int unsigned ADDR_CFG    = 1;
  localparam int unsigned ADDR_RELOAD = 2;
  localparam int unsigned ADDR_CMP    = 3;
  localparam int unsigned ADDR_STAT   = 4;
  localparam int unsigned ADDR_CLR    = 5;
  localparam int unsigned NUM_SHADOW  = 2;
  localparam int unsigned SH_RELOAD   = 0;
  localparam int unsigned SH_CMP      = 1;

  typedef struct packed {
    logic               pol;
    logic [PRESC_W-1:0] presc;
  } shape_t;
endpackage

// File: rtl/lpwm_shadow.sv
module lpwm_shadow #(
  parameter int W   = 16,
  parameter int LAT = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] value,
  output logic         fire,
  output logic         busy
);
  localparam int LW = $clog2(LAT + 1);

  logic [LW-1:0] wait_q;
  logic [W-1:0]  hold_q;

  assign fire = (wait_q == LW'(1)) && !load;
  assign busy = (wait_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_q <= '0;
      hold_q <= '0;
      value  <= '0;
    end else if (load) begin
      wait_q <= LW'(LAT);
      hold_q <= din;
    end else if (busy) begin
      wait_q <= wait_q - LW'(1);
      if (fire) value <= hold_q;
    end
  end
endmodule

// File: rtl/lpwm_regs.sv
module lpwm_regs
  import lpwm_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int WR_LAT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              en,
  output logic              run,
  output shape_t            shape,
  output logic [CNT_W-1:0]  reload_val,
  output logic [CNT_W-1:0]  cmp_val,
  output logic [NUM_SHADOW-1:0] flags
);
  localparam int SHW = $bits(shape_t);

  logic wr_ctrl, wr_cfg, wr_clr;
  logic [NUM_SHADOW-1:0] sh_load, sh_fire, sh_busy;
  logic [CNT_W-1:0] sh_val [NUM_SHADOW];
  logic unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:CNT_W];

  assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(ADDR_CTRL));
  assign wr_cfg  = bus_wr && (bus_addr == ADDR_W'(ADDR_CFG));
  assign wr_clr  = bus_wr && (bus_addr == ADDR_W'(ADDR_CLR));
  assign sh_load[SH_RELOAD] = bus_wr && en && (bus_addr == ADDR_W'(ADDR_RELOAD));
  assign sh_load[SH_CMP]    = bus_wr && en && (bus_addr == ADDR_W'(ADDR_CMP));

  for (genvar i = 0; i < NUM_SHADOW; i++) begin : g_shadow
    lpwm_shadow #(.W(CNT_W), .LAT(WR_LAT)) u_shadow (
      .clk   (clk),
      .rst   (rst),
      .load  (sh_load[i]),
      .din   (bus_wdata[CNT_W-1:0]),
      .value (sh_val[i]),
      .fire  (sh_fire[i]),
      .busy  (sh_busy[i])
    );

    always_ff @(posedge clk) begin
      if (rst)
        flags[i] <= 1'b0;
      else
        flags[i] <= sh_fire[i] | (flags[i] & ~(wr_clr & bus_wdata[i]));
    end
  end

  assign reload_val = sh_val[SH_RELOAD];
  assign cmp_val    = sh_val[SH_CMP];

  always_ff @(posedge clk) begin
    if (rst) begin
      en  <= 1'b0;
      run <= 1'b0;
    end else if (wr_ctrl) begin
      en <= bus_wdata[0];
      if (!bus_wdata[0])
        run <= 1'b0;
      else if (bus_wdata[1] && en)
        run <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      shape <= '0;
    else if (wr_cfg && !en)
      shape <= shape_t'(bus_wdata[SHW-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= '0;
      if (bus_rd) begin
        case (bus_addr)
          ADDR_W'(ADDR_CTRL):   bus_rdata <= DATA_W'({run, en});
          ADDR_W'(ADDR_CFG):    bus_rdata <= DATA_W'(shape);
          ADDR_W'(ADDR_RELOAD): bus_rdata <= DATA_W'(reload_val);
          ADDR_W'(ADDR_CMP):    bus_rdata <= DATA_W'(cmp_val);
          ADDR_W'(ADDR_STAT):   bus_rdata <= DATA_W'(flags);
          default:              bus_rdata <= '0;
        endcase
      end
    end
  end

  logic unused_busy;
  assign unused_busy = ^sh_busy;
endmodule

// File: rtl/lpwm_presc.sv
module lpwm_presc
  import lpwm_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic [PRESC_W-1:0] presc,
  output logic               tick
);
  localparam int DIV_W = (1 << PRESC_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] limit;

  assign limit = {DIV_W{1'b1}} >> (DIV_W - int'(presc));
  assign tick  = run && (div_q == limit);

  always_ff @(posedge clk) begin
    if (rst || !run)
      div_q <= '0;
    else if (tick)
      div_q <= '0;
    else
      div_q <= div_q + DIV_W'(1);
  end
endmodule

// File: rtl/lpwm_core.sv
module lpwm_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             run,
  input  logic             tick,
  input  logic             pol,
  input  logic [CNT_W-1:0] reload_val,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] cnt,
  output logic             wave
);
  always_ff @(posedge clk) begin
    if (rst || !run)
      cnt <= '0;
    else if (tick)
      cnt <= (cnt >= reload_val) ? '0 : cnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)
      wave <= 1'b0;
    else if (!en)
      wave <= pol;
    else
      wave <= (cnt > cmp_val) ^ pol;
  end
endmodule

// File: rtl/lpwm_timer.sv
module lpwm_timer
  import lpwm_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int WR_LAT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pwm_out
);
  logic en, run, tick;
  shape_t shape;
  logic [CNT_W-1:0] reload_val, cmp_val, cnt;
  logic [NUM_SHADOW-1:0] flags;

  lpwm_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .WR_LAT(WR_LAT)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .en         (en),
    .run        (run),
    .shape      (shape),
    .reload_val (reload_val),
    .cmp_val    (cmp_val),
    .flags      (flags)
  );

  lpwm_presc u_presc (
    .clk   (clk),
    .rst   (rst),
    .run   (run),
    .presc (shape.presc),
    .tick  (tick)
  );

  lpwm_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .run        (run),
    .tick       (tick),
    .pol        (shape.pol),
    .reload_val (reload_val),
    .cmp_val    (cmp_val),
    .cnt        (cnt),
    .wave       (pwm_out)
  );
endmodule

// File: rtl/lpwm_timer_chk.sv
module lpwm_timer_chk
  import lpwm_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int WR_LAT = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              pwm_out,
  input logic              en,
  input logic              run,
  input logic              pol,
  input logic [PRESC_W-1:0] presc,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  reload_val,
  input logic [1:0]        flags
);
  localparam int SW = $clog2(WR_LAT + 3);
  localparam logic [SW-1:0] SMAX = {SW{1'b1}};

  logic [SW-1:0] since_q;
  logic acc_rl, clr_rl;

  assign acc_rl = bus_wr && en && (bus_addr == ADDR_W'(ADDR_RELOAD));
  assign clr_rl = bus_wr && bus_wdata[0] && (bus_addr == ADDR_W'(ADDR_CLR));

  always_ff @(posedge clk) begin
    if (rst)
      since_q <= '0;
    else if (acc_rl)
      since_q <= SW'(1);
    else if (since_q != '0 && since_q != SMAX)
      since_q <= since_q + SW'(1);
  end

  assert_cfg_locked_R2: assert property (@(posedge clk) disable iff (rst)
    en |=> ($stable(presc) && $stable(pol)));

  assert_reload_only_on_apply_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(reload_val) |-> ($past(since_q) == SW'(WR_LAT)));

  assert_ok_delay_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(flags[0]) |-> (since_q == SW'(WR_LAT + 1)));

  assert_clear_w1c_R5: assert property (@(posedge clk) disable iff (rst)
    (clr_rl && since_q != SW'(WR_LAT)) |=> !flags[0]);

  assert_clear_reads_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(ADDR_CLR)) |=> (bus_rdata == '0));

  assert_idle_level_R8: assert property (@(posedge clk) disable iff (rst)
    !en |=> (pwm_out == $past(pol)));

  assert_stopped_counter_R9: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == '0));

  assert_no_read_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));
endmodule

bind lpwm_timer lpwm_timer_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .WR_LAT(WR_LAT)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .pwm_out    (pwm_out),
  .en         (en),
  .run        (run),
  .pol        (shape.pol),
  .presc      (shape.presc),
  .cnt        (cnt),
  .reload_val (reload_val),
  .flags      (flags)
);

// File: tb/lpwm_timer_bench.sv
module lpwm_timer_bench;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0;
  logic bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic pwm_out;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  lpwm_timer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .WR_LAT(3)) u_lpwm_timer (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = ADDR_W'(addr); bus_wdata = DATA_W'(data);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int addr, output int data);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = ADDR_W'(addr);
    @(negedge clk);
    bus_rd = 1'b0;
    data = int'(bus_rdata);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_case(input int p, input int rl, input int c, input int pol);
    int period, high, exp_high, gap;
    wr(0, 0);
    wr(1, (pol << 3) | p);
    wr(0, 1);
    wr(2, rl);
    wr(3, c);
    idle(5);
    wr(0, 3);
    period = (rl + 1) << p;
    idle(2 * period + 4);
    high = 0;
    for (int k = 0; k < period; k++) begin
      @(negedge clk);
      if (pwm_out) high++;
    end
    exp_high = (c < rl) ? ((rl - c) << p) : 0;
    if (pol != 0) exp_high = period - exp_high;
    if (pol != 0) check("R8 inverted high time", high, exp_high);
    else          check("R7 high time", high, exp_high);
    if (pol == 0 && c < rl) begin
      while (!(pwm_out == 1'b0)) @(negedge clk);
      while (!(pwm_out == 1'b1)) @(negedge clk);
      gap = 0;
      @(negedge clk);
      gap++;
      while (!(pwm_out == 1'b1 && gap > 1) && gap < 4 * period) begin
        while (pwm_out == 1'b1 && gap < 4 * period) begin @(negedge clk); gap++; end
        while (pwm_out == 1'b0 && gap < 4 * period) begin @(negedge clk); gap++; end
      end
      check("R6 period", gap, period);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    idle(3);
    rst = 1'b0;
    idle(1);
    check("R1 pwm_out after reset", pwm_out, 0);
    for (int a = 0; a < 6; a++) begin
      rd(a, v);
      check("R1 register reset value", v, 0);
    end
    check("R10 rdata idle", bus_rdata, 0);

    // R9: start refused while disabled, honoured once enabled
    wr(0, 3);
    rd(0, v); check("R9 start refused when off", v, 1);
    wr(0, 3);
    rd(0, v); check("R9 start honoured when on", v, 3);

    // R2: shape write ignored while enabled
    wr(1, 15);
    wr(0, 0);
    rd(0, v); check("R9 disable clears run", v, 0);
    rd(1, v); check("R2 cfg locked while enabled", v, 0);
    wr(1, 11);
    rd(1, v); check("R2 cfg accepted while disabled", v, 11);
    idle(2);
    check("R8 idle level follows polarity", pwm_out, 1);
    wr(1, 0);
    idle(2);
    check("R8 idle level low", pwm_out, 0);

    // R3: reload and compare writes ignored while disabled
    wr(2, 85);
    wr(3, 17);
    idle(5);
    rd(2, v); check("R3 reload ignored when off", v, 0);
    rd(3, v); check("R3 compare ignored when off", v, 0);
    rd(4, v); check("R3 no flag when off", v, 0);

    // R4: delayed take-effect and flags
    wr(0, 1);
    wr(2, 9);
    rd(2, v); check("R4 old reload before delay", v, 0);
    idle(2);
    rd(2, v); check("R4 new reload after delay", v, 9);
    rd(4, v); check("R4 reload flag", v, 1);
    wr(3, 4);
    idle(4);
    rd(3, v); check("R4 compare applied", v, 4);
    rd(4, v); check("R4 both flags", v, 3);

    // R5: write-one-to-clear
    wr(5, 1);
    rd(4, v); check("R5 clear bit0 only", v, 2);
    wr(5, 0);
    rd(4, v); check("R5 zero write no effect", v, 2);
    wr(5, 2);
    rd(4, v); check("R5 clear bit1", v, 0);
    rd(5, v); check("R5 clear reads zero", v, 0);

    // R6/R7/R8 sweep
    for (int p = 0; p < 4; p++) begin
      for (int ri = 0; ri < 3; ri++) begin
        int rl;
        rl = (ri == 0) ? 1 : ((ri == 1) ? 3 : 6);
        for (int c = 0; c <= rl + 1; c++) begin
          for (int pol = 0; pol < 2; pol++) begin
            run_case(p, rl, c, pol);
          end
        end
      end
    end

    wr(0, 0);
    idle(2);
    check("R8 idle after stop", pwm_out, 1);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule